// File: doc/BRIEF.md
# Bank-Switching Memory Address Mapper

This block widens the 16-bit logical address of an 8-bit processor into a 24-bit physical address for a larger memory system. The logical space has two parts. The top part is a shared common window. It always lands on one fixed physical page, whatever bank is selected. The part below it is the banked window. Its upper physical address bits come from a bank number that software holds in a register. Because the common window never moves, code that runs there can change the bank without losing its own instructions or data.

Software controls the mapper through two I/O ports:

- The bank port holds the bank number.
- The mode port picks where the common window starts. It starts at 0xC000 for a 48 KB / 16 KB split, or at 0x8000 for a 32 KB / 32 KB split.

Both ports can be read back. The address translation is combinational. It uses the logical address and the registered bank state, so every memory access is mapped in the same cycle it is presented.

Top module: `bank_mapper`

## Requirements
- R1: After reset the bank register is 0 and the split is 48/16. A logical address below 0xC000 then maps to physical 0x00 followed by the 16 logical bits, with isCommon low.
- R2: In the 48/16 split (mode bit 0), a logical address of 0xC000 or above has isCommon high. It maps to physical {COMMON_PAGE, logical address}.
- R3: In the 32/32 split (mode bit 1), the common window starts at 0x8000. Addresses 0x8000 and above are common, and addresses up to 0x7FFF are banked.
- R4: A banked access maps to physical {bank register, logical address}. The bank register is 8 bits and forms physical bits 23:16.
- R5: The physical address of a common access does not depend on the bank register.
- R6: An I/O write to BANK_PORT (default 0x40) loads ioWrData into the bank register at the clock edge. Accesses in the cycle of the write still use the old bank. The new bank applies from the next cycle.
- R7: An I/O write to MODE_PORT (default 0x41) loads bit 0 of ioWrData as the split mode, where 0 selects 48/16 and 1 selects 32/32. Bits 7:1 are ignored.
- R8: When ioRd is high, ioRdData returns one of three values:
  - the bank register, for BANK_PORT;
  - {7'b0, mode}, for MODE_PORT;
  - 0, for any other port.
  A read in the same cycle as a write returns the old value.
- R9: A write to any other port changes neither the bank register nor the mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| logAddr | input | 16 | Logical address from the processor |
| ioAddr | input | 8 | I/O port address |
| ioWrData | input | 8 | I/O write data |
| ioWr | input | 1 | I/O write strobe |
| ioRd | input | 1 | I/O read strobe |
| physAddr | output | 24 | Translated physical address |
| isCommon | output | 1 | High when the access falls in the common window |
| ioRdData | output | 8 | I/O read data |

## Verification
A bank-port write and a banked memory translation can happen in the same cycle. A read of a port can also happen in the same cycle as a write to it. The bench provokes the first case by holding a banked logical address while it pulses the bank write. It expects the old bank in physAddr before the edge and the new bank after it. For the second case it raises ioRd and ioWr together on the bank port and expects ioRdData to show the previous bank until the edge.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

  typedef struct packed {
    logic bankWe;
    logic modeWe;
    logic rdBank;
    logic rdMode;
  } mapStrobe_t;

  typedef enum logic {
    SPLIT_48_16 = 1'b0,
    SPLIT_32_32 = 1'b1
  } split_e;

endpackage

// File: rtl/mapper_ctrl.sv
module mapper_ctrl
  import mapper_pkg::*;
#(
  parameter int PORT_AW = 8,
  parameter logic [PORT_AW-1:0] BANK_PORT = 8'h40,
  parameter logic [PORT_AW-1:0] MODE_PORT = 8'h41
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PORT_AW-1:0] ioAddr,
  input  logic               ioWr,
  input  logic               ioRd,
  output mapStrobe_t         strb
);

  logic hitBank;
  logic hitMode;

  assign hitBank = (ioAddr == BANK_PORT);
  assign hitMode = (ioAddr == MODE_PORT);

  always_comb begin
    strb        = '0;
    strb.bankWe = ioWr & hitBank;
    strb.modeWe = ioWr & hitMode;
    strb.rdBank = ioRd & hitBank;
    strb.rdMode = ioRd & hitMode;
  end

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.bankWe, strb.modeWe})); // R9

  AST_ONE_READ: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.rdBank, strb.rdMode})); // R8

endmodule

// File: rtl/mapper_dp.sv
module mapper_dp
  import mapper_pkg::*;
#(
  parameter int LOG_AW  = 16,
  parameter int PHYS_AW = 24,
  parameter int BANK_W  = 8,
  parameter int DATA_W  = 8,
  parameter logic [PHYS_AW-LOG_AW-1:0] COMMON_PAGE = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  mapStrobe_t         strb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [LOG_AW-1:0]  logAddr,
  output logic [PHYS_AW-1:0] physAddr,
  output logic               isCommon,
  output logic [DATA_W-1:0]  rdData
);

  localparam int PAGE_W = PHYS_AW - LOG_AW;

  logic [BANK_W-1:0] bankReg;
  split_e            splitMode;
  logic [PAGE_W-1:0] bankPage;
  logic              commonHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankReg   <= '0;
      splitMode <= SPLIT_48_16;
    end else begin
      if (strb.bankWe) bankReg <= wrData[BANK_W-1:0];
      if (strb.modeWe) splitMode <= split_e'(wrData[0]);
    end
  end

  generate
    if (BANK_W >= PAGE_W) begin : g_trunc
      assign bankPage = bankReg[PAGE_W-1:0];
    end else begin : g_extend
      assign bankPage = {{(PAGE_W-BANK_W){1'b0}}, bankReg};
    end
  endgenerate

  always_comb begin
    case (splitMode)
      SPLIT_48_16: commonHit = &logAddr[LOG_AW-1 -: 2];
      default:     commonHit = logAddr[LOG_AW-1];
    endcase
  end

  assign isCommon = commonHit;
  assign physAddr = commonHit ? {COMMON_PAGE, logAddr} : {bankPage, logAddr};

  always_comb begin
    if (strb.rdBank)      rdData = DATA_W'(bankReg);
    else if (strb.rdMode) rdData = DATA_W'(splitMode);
    else                  rdData = '0;
  end

  AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.bankWe |=> (bankReg == $past(wrData[BANK_W-1:0]))); // R6

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.bankWe |=> $stable(bankReg)); // R9

  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.modeWe |=> (splitMode == split_e'($past(wrData[0])))); // R7

  AST_COMMON_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    (isCommon && $past(isCommon) && $stable(logAddr)) |-> $stable(physAddr)); // R5

  AST_SPLIT_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (splitMode == SPLIT_32_32 && !logAddr[LOG_AW-1]) |-> !isCommon); // R3

  AST_SPLIT_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (&logAddr[LOG_AW-1 -: 2]) |-> isCommon); // R2

endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import mapper_pkg::*;
#(
  parameter int LOG_AW  = 16,
  parameter int PHYS_AW = 24,
  parameter int BANK_W  = 8,
  parameter int DATA_W  = 8,
  parameter int PORT_AW = 8,
  parameter logic [PORT_AW-1:0] BANK_PORT = 8'h40,
  parameter logic [PORT_AW-1:0] MODE_PORT = 8'h41,
  parameter logic [PHYS_AW-LOG_AW-1:0] COMMON_PAGE = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LOG_AW-1:0]  logAddr,
  input  logic [PORT_AW-1:0] ioAddr,
  input  logic [DATA_W-1:0]  ioWrData,
  input  logic               ioWr,
  input  logic               ioRd,
  output logic [PHYS_AW-1:0] physAddr,
  output logic               isCommon,
  output logic [DATA_W-1:0]  ioRdData
);

  mapStrobe_t strb;

  mapper_ctrl #(
    .PORT_AW(PORT_AW), .BANK_PORT(BANK_PORT), .MODE_PORT(MODE_PORT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd), .strb(strb)
  );

  mapper_dp #(
    .LOG_AW(LOG_AW), .PHYS_AW(PHYS_AW), .BANK_W(BANK_W), .DATA_W(DATA_W),
    .COMMON_PAGE(COMMON_PAGE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(ioWrData), .logAddr(logAddr),
    .physAddr(physAddr), .isCommon(isCommon), .rdData(ioRdData)
  );

endmodule

// File: tb/tb_bank_mapper.sv
`timescale 1ns/1ps
module tb_bank_mapper;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] logAddr = '0;
  logic [7:0]  ioAddr = '0;
  logic [7:0]  ioWrData = '0;
  logic        ioWr = 1'b0;
  logic        ioRd = 1'b0;
  logic [23:0] physAddr;
  logic        isCommon;
  logic [7:0]  ioRdData;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bank_mapper #(.COMMON_PAGE(8'hF0)) dut (
    .clk(clk), .rstN(rstN), .logAddr(logAddr), .ioAddr(ioAddr), .ioWrData(ioWrData),
    .ioWr(ioWr), .ioRd(ioRd), .physAddr(physAddr), .isCommon(isCommon), .ioRdData(ioRdData)
  );

  // {mode, bank, logAddr, expected physAddr, expected isCommon}
  localparam logic [49:0] VEC [18] = '{
    {1'b0, 8'h01, 16'h0000, 24'h010000, 1'b0},
    {1'b0, 8'h01, 16'h8000, 24'h018000, 1'b0},
    {1'b0, 8'h01, 16'hBFFF, 24'h01BFFF, 1'b0},
    {1'b0, 8'h01, 16'hC000, 24'hF0C000, 1'b1},
    {1'b0, 8'h01, 16'hFFFF, 24'hF0FFFF, 1'b1},
    {1'b0, 8'h5A, 16'h7FFF, 24'h5A7FFF, 1'b0},
    {1'b0, 8'h5A, 16'hBFFE, 24'h5ABFFE, 1'b0},
    {1'b0, 8'h5A, 16'hC001, 24'hF0C001, 1'b1},
    {1'b1, 8'h02, 16'h0000, 24'h020000, 1'b0},
    {1'b1, 8'h02, 16'h7FFF, 24'h027FFF, 1'b0},
    {1'b1, 8'h02, 16'h8000, 24'hF08000, 1'b1},
    {1'b1, 8'h02, 16'hBFFF, 24'hF0BFFF, 1'b1},
    {1'b1, 8'hFF, 16'h1234, 24'hFF1234, 1'b0},
    {1'b1, 8'hFF, 16'h8001, 24'hF08001, 1'b1},
    {1'b1, 8'hFF, 16'hC000, 24'hF0C000, 1'b1},
    {1'b0, 8'h00, 16'h4321, 24'h004321, 1'b0},
    {1'b0, 8'hFF, 16'hFFFE, 24'hF0FFFE, 1'b1},
    {1'b0, 8'hFF, 16'h0001, 24'hFF0001, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ioWrite(input logic [7:0] port, input logic [7:0] data);
    @(negedge clk);
    ioAddr = port; ioWrData = data; ioWr = 1'b1;
    @(negedge clk);
    ioWr = 1'b0;
  endtask

  task automatic ioRead(input logic [7:0] port, output logic [7:0] data);
    @(negedge clk);
    ioAddr = port; ioRd = 1'b1;
    #1 data = ioRdData;
    @(negedge clk);
    ioRd = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    logAddr = 16'hABCD; #1;
    check("R1 phys", physAddr, 24'h00ABCD);
    check("R1 com", isCommon, 0);
    ioRead(8'h40, rd); check("R1 bank", rd, 8'h00);
    ioRead(8'h41, rd); check("R1 mode", rd, 8'h00);
    @(negedge clk); logAddr = 16'hC000; #1;
    check("R2 reset top", physAddr, 24'hF0C000);

    // R2 R3 R4 R5 table sweep
    for (int i = 0; i < 18; i++) begin
      ioWrite(8'h41, {7'b0, VEC[i][49]});
      ioWrite(8'h40, VEC[i][48:41]);
      @(negedge clk); logAddr = VEC[i][40:25]; #1;
      check(VEC[i][0] ? "R2/R3/R5 common" : "R3/R4 banked", physAddr, VEC[i][24:1]);
      check("R2/R3 isCommon", isCommon, VEC[i][0]);
    end

    // R6 write and translation in the same cycle
    ioWrite(8'h41, 8'h00);
    ioWrite(8'h40, 8'h11);
    @(negedge clk);
    logAddr = 16'h1000; ioAddr = 8'h40; ioWrData = 8'h22; ioWr = 1'b1; ioRd = 1'b1;
    #1;
    check("R6 old bank", physAddr, 24'h111000);
    check("R8 read old", ioRdData, 8'h11);
    @(posedge clk); #1;
    ioWr = 1'b0;
    check("R6 new bank", physAddr, 24'h221000);
    check("R8 read new", ioRdData, 8'h22);
    @(negedge clk); ioRd = 1'b0;

    // R5 common unchanged across a bank switch
    @(negedge clk); logAddr = 16'hD000; #1;
    check("R5 before", physAddr, 24'hF0D000);
    ioWrite(8'h40, 8'h99); #1;
    check("R5 after", physAddr, 24'hF0D000);

    // R7 only bit 0 of the mode write counts
    ioWrite(8'h41, 8'hFE);
    ioRead(8'h41, rd); check("R7 mode ignore hi", rd, 8'h00);
    @(negedge clk); logAddr = 16'h8000; #1;
    check("R7 48/16 kept", isCommon, 0);
    ioWrite(8'h41, 8'h03);
    ioRead(8'h41, rd); check("R7 mode set", rd, 8'h01);
    @(negedge clk); logAddr = 16'h8000; #1;
    check("R7 32/32", isCommon, 1);

    // R9 writes to other ports
    ioWrite(8'h42, 8'h77);
    ioWrite(8'h3F, 8'h00);
    ioRead(8'h40, rd); check("R9 bank kept", rd, 8'h99);
    ioRead(8'h41, rd); check("R9 mode kept", rd, 8'h01);

    // R8 unselected read port and no-read
    ioRead(8'h55, rd); check("R8 other port", rd, 8'h00);
    @(negedge clk); ioAddr = 8'h40; ioRd = 1'b0; #1;
    check("R8 no strobe", ioRdData, 8'h00);

    // R1 reset mid-run
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    logAddr = 16'h9000; #1;
    check("R1 reset again", physAddr, 24'h009000);
    check("R1 reset com", isCommon, 0);

    finishRun();
  end

endmodule